// File: doc/BRIEF.md
# Complementary PWM Duty Buffer Transfer

This block is one channel of a complementary PWM timer. Two up/down counters run in lockstep: a lead counter that swings between a fixed dead-time offset and the period, and a trailing counter that swings between zero and the period minus that offset. A duty value is written into a buffer register. A transfer rule then copies it into the compare register that drives a positive-phase pin and an inverted-phase pin. The inverted pin switches only after the trailing counter has passed the compare value, so the two pins are never active together.

The copy from buffer to compare normally follows a programmable transfer mode: at the trough, at the crest, at both, or at once on the write. Duty values at the two extremes override that mode. A buffered value at or above the period is copied only at the next trough. Once copied, it pins the positive output high and the inverted output low. A later write that brings the duty back below the period is also copied at the first trough, whatever the mode. After that, the programmed mode applies again. The buffer comes out of reset holding all ones, but that value is never copied. Only a written value is.

Top module: `cpwm_duty_xfer`

## Requirements
- R1: After reset the compare value is 0, the period is 20, the transfer mode is trough, the buffer holds 0xFFFF, and pos_o, neg_o, udf_o and crest_o are all 0.
- R2: While en_i is high the trailing counter steps 0,1,..,(period-2),..,1,0. udf_o is a one-cycle pulse once per turn at zero, and successive pulses are 2*(period-2) cycles apart. crest_o pulses once per turn at the top. While en_i is low the counters, outputs and flags hold.
- R3: In transfer mode 2'b00 a written buffer value is copied into the compare register at the edge that ends a cycle in which udf_o is high, and never at a crest.
- R4: In transfer mode 2'b01 the copy happens only at the edge that ends a cycle in which crest_o is high.
- R5: In transfer mode 2'b10 the copy happens at the first crest or trough after the write.
- R6: In transfer mode 2'b11 a buffer write below the period, made while no extreme condition holds, appears on cmp_o in the cycle after the write.
- R7: A buffer write at or above the period is copied only at the next trough, in every transfer mode, including 2'b11 and 2'b01.
- R8: While the compare value is at or above the period, pos_o is 1 and neg_o is 0 in every cycle.
- R9: While the compare value is at or above the period, or while such a write is still pending, a buffer write below the period is copied at the first trough, whatever the mode. Later writes follow the mode again.
- R10: The buffer's reset value is never copied. A copy takes place only when the buffer has been written since the last copy.
- R11: pos_o is 1 when the lead counter is at or below the compare value. neg_o is 1 when the trailing counter is above it. For a compare value of 7 and period 20, one period holds 11 cycles of pos_o, 21 cycles of neg_o and no cycle with both.
- R12: A write with wr_sel_i = 0 sets the period, 1 the buffer and 2 the transfer mode (from wr_data_i[1:0]). A new period takes effect on the counter turns that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 period, 1 buffer, 2 mode |
| wr_data_i | input | 16 | Write data |
| pos_o | output | 1 | Positive-phase PWM output |
| neg_o | output | 1 | Inverted-phase PWM output |
| udf_o | output | 1 | Trailing counter underflow pulse |
| crest_o | output | 1 | Lead counter crest pulse |
| cmp_o | output | 16 | Compare value currently in effect |

## Verification
A register write lands on the rising edge inside the write cycle. In mode 2'b11 the new compare value can therefore be read at the next falling edge. An event-driven copy happens on the edge that closes the cycle in which udf_o or crest_o is high, so the bench waits until it sees the flag at a falling edge and reads cmp_o one falling edge later. The PWM pins are combinational from the counters and the compare register, so duty widths are counted over a full window of 2*(period-2) falling edges. The ordering tests write right after one kind of event, so the other kind always comes first and the mode rule is what decides the copy.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic [1:0] {
    XFER_TROUGH = 2'b00,
    XFER_CREST  = 2'b01,
    XFER_BOTH   = 2'b10,
    XFER_IMM    = 2'b11
  } xfer_mode_e;

  localparam logic [1:0] SEL_PRD  = 2'd0;
  localparam logic [1:0] SEL_BUF  = 2'd1;
  localparam logic [1:0] SEL_MODE = 2'd2;
endpackage

// File: rtl/cpwm_counters.sv
module cpwm_counters #(
  parameter int DW     = 16,
  parameter int DT_OFF = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [DW-1:0] prd_i,
  output logic [DW-1:0] c0_o,
  output logic [DW-1:0] c1_o,
  output logic          udf_o,
  output logic          crest_o
);
  localparam logic [DW-1:0] OFF = DW'(DT_OFF);
  localparam int NLANE = 2;

  logic [DW-1:0] cnt_q [NLANE];
  logic          up_q;
  logic [DW-1:0] top;

  assign top     = prd_i - OFF;
  assign crest_o = en_i && up_q && (cnt_q[1] >= top);
  assign udf_o   = en_i && !up_q && (cnt_q[1] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       up_q <= 1'b1;
    else if (crest_o)  up_q <= 1'b0;
    else if (udf_o)    up_q <= 1'b1;
  end

  // lane 0 leads by the dead-time offset, lane 1 starts at zero
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam logic [DW-1:0] BASE = (g == 0) ? OFF : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_q[g] <= BASE;
      else if (en_i) begin
        if (crest_o)     cnt_q[g] <= cnt_q[g] - 1'b1;
        else if (udf_o)  cnt_q[g] <= BASE + 1'b1;
        else if (up_q)   cnt_q[g] <= cnt_q[g] + 1'b1;
        else             cnt_q[g] <= cnt_q[g] - 1'b1;
      end
    end
  end

  assign c0_o = cnt_q[0];
  assign c1_o = cnt_q[1];

  assert_lane_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q[0] == cnt_q[1] + OFF);

  assert_udf_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    udf_o |=> (cnt_q[1] == DW'(1)) && up_q);
endmodule

// File: rtl/cpwm_xfer_ctrl.sv
module cpwm_xfer_ctrl
  import cpwm_pkg::*;
#(
  parameter int              DW      = 16,
  parameter logic [DW-1:0]   BUF_RST = '1,
  parameter logic [DW-1:0]   PRD_RST = DW'(20)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          udf_i,
  input  logic          crest_i,
  output logic [DW-1:0] prd_o,
  output logic [DW-1:0] cmp_o
);
  logic [DW-1:0] prd_q, buf_q, cmp_q;
  xfer_mode_e    mode_q;
  logic          force_q, dirty_q;
  logic          buf_wr, frc_nxt, mode_evt, evt;

  assign buf_wr  = wr_en_i && (wr_sel_i == SEL_BUF);
  // extreme request, or leaving/pending an extreme state
  assign frc_nxt = (wr_data_i >= prd_q) || (cmp_q >= prd_q) || force_q;

  always_comb begin
    unique case (mode_q)
      XFER_TROUGH: mode_evt = udf_i;
      XFER_CREST:  mode_evt = crest_i;
      XFER_BOTH:   mode_evt = udf_i || crest_i;
      default:     mode_evt = 1'b0;
    endcase
  end

  assign evt = force_q ? udf_i : mode_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prd_q   <= PRD_RST;
      buf_q   <= BUF_RST;
      cmp_q   <= '0;
      mode_q  <= XFER_TROUGH;
      force_q <= 1'b0;
      dirty_q <= 1'b0;
    end else begin
      if (evt && dirty_q) begin
        cmp_q   <= buf_q;
        dirty_q <= 1'b0;
        force_q <= 1'b0;
      end
      if (wr_en_i) begin
        case (wr_sel_i)
          SEL_PRD:  prd_q  <= wr_data_i;
          SEL_MODE: mode_q <= xfer_mode_e'(wr_data_i[1:0]);
          SEL_BUF: begin
            buf_q   <= wr_data_i;
            dirty_q <= 1'b1;
            force_q <= frc_nxt;
            if (mode_q == XFER_IMM && !frc_nxt) begin
              cmp_q   <= wr_data_i;
              dirty_q <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign prd_o = prd_q;
  assign cmp_o = cmp_q;

  // compare only moves on an event or a buffer write
  assert_cmp_source_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cmp_q) |-> $past(udf_i || crest_i || buf_wr));

  // while an extreme transfer is pending, only a trough moves the compare
  assert_forced_trough_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(force_q) && !$stable(cmp_q)) |-> $past(udf_i));
endmodule

// File: rtl/cpwm_out_stage.sv
module cpwm_out_stage #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] c0_i,
  input  logic [DW-1:0] c1_i,
  input  logic [DW-1:0] cmp_i,
  input  logic [DW-1:0] prd_i,
  output logic          pos_o,
  output logic          neg_o
);
  logic forced;

  assign forced = cmp_i >= prd_i;
  assign pos_o  = forced | (c0_i <= cmp_i);
  // trailing lane lags by the offset, giving the dead band
  assign neg_o  = !forced && (c1_i > cmp_i);
endmodule

// File: rtl/cpwm_duty_xfer.sv
module cpwm_duty_xfer #(
  parameter int            DW      = 16,
  parameter int            DT_OFF  = 2,
  parameter logic [DW-1:0] PRD_RST = DW'(20),
  parameter logic [DW-1:0] BUF_RST = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          pos_o,
  output logic          neg_o,
  output logic          udf_o,
  output logic          crest_o,
  output logic [DW-1:0] cmp_o
);
  logic [DW-1:0] prd, c0, c1;

  cpwm_counters #(.DW(DW), .DT_OFF(DT_OFF)) i_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .prd_i(prd),
    .c0_o(c0), .c1_o(c1), .udf_o(udf_o), .crest_o(crest_o)
  );

  cpwm_xfer_ctrl #(.DW(DW), .BUF_RST(BUF_RST), .PRD_RST(PRD_RST)) i_xfer (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .udf_i(udf_o), .crest_i(crest_o),
    .prd_o(prd), .cmp_o(cmp_o)
  );

  cpwm_out_stage #(.DW(DW)) i_out (
    .c0_i(c0), .c1_i(c1), .cmp_i(cmp_o), .prd_i(prd),
    .pos_o(pos_o), .neg_o(neg_o)
  );

  assert_no_overlap_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pos_o && neg_o));
endmodule

// File: tb/test_cpwm_duty_xfer.sv
`timescale 1ns/1ps
module test_cpwm_duty_xfer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        pos_o, neg_o, udf_o, crest_o;
  logic [15:0] cmp_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk_i = ~clk_i;

  cpwm_duty_xfer i_cpwm_duty_xfer (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .pos_o(pos_o), .neg_o(neg_o),
    .udf_o(udf_o), .crest_o(crest_o), .cmp_o(cmp_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // returns at the falling edge after the event edge
  task automatic wait_evt(input bit crest, input string req);
    int n = 0;
    while (!(crest ? crest_o : udf_o)) begin
      @(negedge clk_i);
      n++;
      if (n > 200) begin
        chk({req, " event timeout"}, 0, 1);
        return;
      end
    end
    @(negedge clk_i);
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk("R1 cmp", cmp_o, 0);
    chk("R1 pos", pos_o, 0);
    chk("R1 neg", neg_o, 0);
    chk("R1 flags", {udf_o, crest_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 cmp after release", cmp_o, 0);
    en_i = 1'b1;
  endtask

  task automatic t_reset_buf_r10;
    wait_evt(1'b0, "R10");
    chk("R10 reset buffer not copied", cmp_o, 0);
  endtask

  task automatic t_trough_r3;
    wr(2'd1, 16'd5);
    wait_evt(1'b1, "R3");
    chk("R3 no copy at crest", cmp_o, 0);
    wait_evt(1'b0, "R3");
    chk("R3 copy at trough", cmp_o, 5);
  endtask

  task automatic t_crest_r4;
    wr(2'd2, 16'd1);
    wait_evt(1'b1, "R4");
    wr(2'd1, 16'd8);
    wait_evt(1'b0, "R4");
    chk("R4 no copy at trough", cmp_o, 5);
    wait_evt(1'b1, "R4");
    chk("R4 copy at crest", cmp_o, 8);
  endtask

  task automatic t_both_r5;
    wr(2'd2, 16'd2);
    wr(2'd1, 16'd6);
    wait_evt(1'b0, "R5");
    chk("R5 copy at trough", cmp_o, 6);
    wr(2'd1, 16'd3);
    wait_evt(1'b1, "R5");
    chk("R5 copy at crest", cmp_o, 3);
  endtask

  task automatic t_imm_r6;
    wr(2'd2, 16'd3);
    wr(2'd1, 16'd9);
    chk("R6 immediate copy", cmp_o, 9);
  endtask

  task automatic t_duty_r11;
    int np = 0, nn = 0, nb = 0;
    wr(2'd1, 16'd7);
    chk("R6 immediate copy 7", cmp_o, 7);
    for (int i = 0; i < 36; i++) begin
      @(negedge clk_i);
      np += int'(pos_o);
      nn += int'(neg_o);
      nb += int'(pos_o && neg_o);
    end
    chk("R11 pos cycles", np, 11);
    chk("R11 neg cycles", nn, 21);
    chk("R11 overlap cycles", nb, 0);
  endtask

  task automatic t_extreme_r7_r8;
    int bad = 0;
    wr(2'd2, 16'd1);
    wait_evt(1'b0, "R7");
    wr(2'd1, 16'd25);
    wait_evt(1'b1, "R7");
    chk("R7 extreme not copied at crest", cmp_o, 7);
    wait_evt(1'b0, "R7");
    chk("R7 extreme copied at trough", cmp_o, 25);
    for (int i = 0; i < 40; i++) begin
      if (!(pos_o === 1'b1 && neg_o === 1'b0)) bad++;
      @(negedge clk_i);
    end
    chk("R8 forced pos=1 neg=0", bad, 0);
  endtask

  task automatic t_return_r9;
    wait_evt(1'b0, "R9");
    wr(2'd1, 16'd7);
    wait_evt(1'b1, "R9");
    chk("R9 return not copied at crest", cmp_o, 25);
    wait_evt(1'b0, "R9");
    chk("R9 return copied at trough", cmp_o, 7);
    wait_evt(1'b1, "R9");
    wr(2'd1, 16'd4);
    wait_evt(1'b0, "R9");
    chk("R9 mode resumes no trough copy", cmp_o, 7);
    wait_evt(1'b1, "R9");
    chk("R9 mode resumes crest copy", cmp_o, 4);
  endtask

  task automatic t_imm_extreme_r7_r9;
    wr(2'd2, 16'd3);
    wr(2'd1, 16'd30);
    chk("R7 extreme not immediate", cmp_o, 4);
    wait_evt(1'b0, "R7");
    chk("R7 extreme copied at trough imm mode", cmp_o, 30);
    wr(2'd1, 16'd3);
    chk("R9 return not immediate", cmp_o, 30);
    wait_evt(1'b0, "R9");
    chk("R9 return copied at trough imm mode", cmp_o, 3);
    wr(2'd1, 16'd5);
    chk("R9 imm resumes", cmp_o, 5);
  endtask

  task automatic t_freeze_r2;
    logic p, n;
    int bad = 0;
    en_i = 1'b0;
    @(negedge clk_i);
    p = pos_o; n = neg_o;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i);
      if (pos_o !== p || neg_o !== n || udf_o || crest_o) bad++;
    end
    chk("R2 hold while disabled", bad, 0);
    en_i = 1'b1;
  endtask

  task automatic measure_udf(input int exp, input string req);
    int n = 0;
    int guard = 0;
    while (!udf_o && guard < 200) begin @(negedge clk_i); guard++; end
    @(negedge clk_i);
    n = 1;
    chk({req, " udf single cycle"}, udf_o, 0);
    while (!udf_o && n < 200) begin @(negedge clk_i); n++; end
    chk({req, " udf spacing"}, n, exp);
  endtask

  task automatic t_period_r2_r12;
    measure_udf(36, "R2");
    wr(2'd0, 16'd24);
    wait_evt(1'b0, "R12");
    measure_udf(44, "R12");
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    checks++;
    $display("FAIL watchdog R2 actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_reset_buf_r10();
    t_trough_r3();
    t_crest_r4();
    t_both_r5();
    t_imm_r6();
    t_duty_r11();
    t_extreme_r7_r8();
    t_return_r9();
    t_imm_extreme_r7_r9();
    t_freeze_r2();
    t_period_r2_r12();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule